// File: doc/BRIEF.md
# I/Q Sample Serial Streamer

This block turns complex baseband samples, each made of an in-phase (I) word and a quadrature (Q) word, into a single-lane synchronous serial stream. The stream uses three wires: a forwarded bit clock, a one-cycle frame strobe and one data line. On the parallel side, the block takes one I/Q pair at a time through a valid/ready handshake. Each accepted pair becomes one frame of twice the word width. The two words in a frame follow each other with no gap.

Two static configuration inputs set the frame layout. One chooses whether the I word or the Q word leads. The other chooses whether each word is sent from its top bit or from its bottom bit. Both inputs are latched when a sample is accepted, so a frame never changes layout partway through. The block accepts the next sample during the last bit of the current frame, so a source that keeps up produces an unbroken stream. When no sample is waiting, the block holds the data and strobe lines low.

Top module: `iq_serial_streamer`

## Requirements
- R1: `ser_clk` is the core clock `clk` forwarded unchanged. `ser_strobe` and `ser_data` change only on its rising edge.
- R2: An accepted pair is sent as 2×`WORD_W` consecutive bits: first the leading word, then the trailing word, with no idle cycle between them. The first bit appears in the cycle after the edge that accepted the pair.
- R3: With `cfg_q_first`=0 the I word leads. With `cfg_q_first`=1 the Q word leads.
- R4: With `cfg_lsb_first`=0 each word is sent from bit `WORD_W-1` down to bit 0. With `cfg_lsb_first`=1 each word is sent from bit 0 up to bit `WORD_W-1`. Both words use the same order.
- R5: `ser_strobe` is high only in the cycle that carries the first bit of a frame. It is low for the other 2×`WORD_W`−1 bit cycles.
- R6: `smp_ready` is high during the last bit cycle of a frame. A pair accepted in that cycle starts its frame in the very next cycle, with no gap.
- R7: While no frame is in progress, `ser_data` and `ser_strobe` are low and `smp_ready` is high.
- R8: Both configuration inputs are sampled only at the edge that accepts a pair. Changing them during a frame does not alter that frame.
- R9: The synchronous active-high `rst` drives `ser_data` and `ser_strobe` low, discards any frame in progress and leaves the block idle with `smp_ready` high.
- R10: `smp_ready` is low in every bit cycle of a frame except the last. A pair offered in those cycles is not taken and does not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_q_first | input | 1 | 1: Q word leads each frame |
| cfg_lsb_first | input | 1 | 1: words sent bit 0 first |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | The block accepts the offered pair at this edge |
| smp_i | input | WORD_W | In-phase word |
| smp_q | input | WORD_W | Quadrature word |
| ser_clk | output | 1 | Forwarded bit clock |
| ser_strobe | output | 1 | High for the first bit of each frame |
| ser_data | output | 1 | Serial data line |

## Verification
A pair accepted at one rising edge shows its first bit and the strobe in the next cycle. Bit b of the frame is due b cycles after that. The return to idle comes one cycle after the last bit unless another pair was accepted during that last bit. The bench drives inputs on falling edges and samples outputs on the falling edge just after the edge that should change them, so each comparison lands on a known bit index. Expected bits come from word selection and index arithmetic for every combination of the two configuration inputs, over back-to-back and gapped sequences. The bench also changes the configuration and offers pairs during frames, and applies reset in the middle of a frame.

// File: rtl/iq_stream_pkg.sv
package iq_stream_pkg;
   // Frame length for a given word width: two words per complex sample.
   function automatic int frame_bits(input int word_w);
      return 2 * word_w;
   endfunction

   // Counter width able to index every bit of a frame.
   function automatic int cnt_bits(input int word_w);
      return (frame_bits(word_w) > 1) ? $clog2(frame_bits(word_w)) : 1;
   endfunction
endpackage

// File: rtl/iq_word_order.sv
module iq_word_order #(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic              rev,
   output logic [WORD_W-1:0] word_out
);
   logic [WORD_W-1:0] flipped;

   for (genvar g = 0; g < WORD_W; g++) begin : g_flip
      assign flipped[g] = word_in[WORD_W-1-g];
   end

   assign word_out = rev ? flipped : word_in;
endmodule

// File: rtl/iq_frame_counter.sv
module iq_frame_counter #(
   parameter int FRAME = 32,
   parameter int CW    = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   output logic          active,
   output logic          last,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LAST_IDX = CW'(FRAME - 1);

   assign last = active && (cnt == LAST_IDX);

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (load) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (last) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (active) begin
         cnt    <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/iq_frame_shifter.sv
module iq_frame_shifter #(
   parameter int FRAME = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             advance,
   input  logic [FRAME-1:0] frame_in,
   output logic             bit_out,
   output logic             strobe
);
   logic [FRAME-1:0] sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh     <= '0;
         strobe <= 1'b0;
      end else if (load) begin
         sh     <= frame_in;
         strobe <= 1'b1;
      end else begin
         sh     <= advance ? (sh << 1) : '0;
         strobe <= 1'b0;
      end
   end

   assign bit_out = sh[FRAME-1];
endmodule

// File: rtl/iq_serial_streamer.sv
module iq_serial_streamer
   import iq_stream_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_q_first,
   input  logic              cfg_lsb_first,
   input  logic              smp_valid,
   output logic              smp_ready,
   input  logic [WORD_W-1:0] smp_i,
   input  logic [WORD_W-1:0] smp_q,
   output logic              ser_clk,
   output logic              ser_strobe,
   output logic              ser_data
);
   localparam int FRAME_LEN = frame_bits(WORD_W);
   localparam int CNT_W     = cnt_bits(WORD_W);

   if (WORD_W < 2) begin : g_bad_width
      $error("iq_serial_streamer: WORD_W must be at least 2");
   end

   logic              active;
   logic              last;
   logic [CNT_W-1:0]  cnt;
   logic              load;
   logic [WORD_W-1:0] lead_w, trail_w, lead_o, trail_o;

   assign smp_ready = !active || last;
   assign load      = smp_valid && smp_ready;
   assign ser_clk   = clk;

   assign lead_w  = cfg_q_first ? smp_q : smp_i;
   assign trail_w = cfg_q_first ? smp_i : smp_q;

   iq_word_order #(.WORD_W(WORD_W)) u_lead (
      .word_in(lead_w), .rev(cfg_lsb_first), .word_out(lead_o));
   iq_word_order #(.WORD_W(WORD_W)) u_trail (
      .word_in(trail_w), .rev(cfg_lsb_first), .word_out(trail_o));

   iq_frame_counter #(.FRAME(FRAME_LEN), .CW(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load(load),
      .active(active), .last(last), .cnt(cnt));

   iq_frame_shifter #(.FRAME(FRAME_LEN)) u_shift (
      .clk(clk), .rst(rst), .load(load),
      .advance(active && !last),
      .frame_in({lead_o, trail_o}),
      .bit_out(ser_data), .strobe(ser_strobe));
endmodule

// File: rtl/iq_streamer_checker.sv
module iq_streamer_checker #(
   parameter int WORD_W = 16
) (
   input logic                                    clk,
   input logic                                    rst,
   input logic                                    smp_valid,
   input logic                                    smp_ready,
   input logic                                    ser_strobe,
   input logic                                    ser_data,
   input logic                                    active,
   input logic [iq_stream_pkg::cnt_bits(WORD_W)-1:0] cnt
);
   localparam int FRAME = iq_stream_pkg::frame_bits(WORD_W);
   localparam int CW    = iq_stream_pkg::cnt_bits(WORD_W);

   // R5: strobe lasts a single cycle
   a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
      ser_strobe |=> !ser_strobe);

   // R5: strobe only follows an accepted pair
   a_r5_strobe_after_accept: assert property (@(posedge clk) disable iff (rst)
      ser_strobe |-> $past(smp_valid && smp_ready));

   // R6: an accepted pair starts its frame on the next cycle
   a_r6_back_to_back: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && smp_ready) |=> ser_strobe);

   // R7: idle lines stay quiet
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !active |-> (!ser_data && !ser_strobe && smp_ready));

   // R10: no acceptance inside a frame except on its last bit
   a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
      (active && cnt != CW'(FRAME - 1)) |-> !smp_ready);

   // R2: bit index advances by one without gaps
   a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
      (active && cnt != CW'(FRAME - 1)) |=> (active && cnt == $past(cnt) + 1'b1));
endmodule

bind iq_serial_streamer iq_streamer_checker #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
   .ser_strobe(ser_strobe), .ser_data(ser_data),
   .active(active), .cnt(cnt));

// File: tb/test_iq_serial_streamer.sv
module test_iq_serial_streamer;
   localparam int W = 16;
   localparam int F = 2 * W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst = 1'b1;
   logic         cfg_q_first = 1'b0, cfg_lsb_first = 1'b0;
   logic         smp_valid = 1'b0;
   logic         smp_ready;
   logic [W-1:0] smp_i = '0, smp_q = '0;
   logic         ser_clk, ser_strobe, ser_data;

   int n_run = 0, n_fail = 0;

   iq_serial_streamer #(.WORD_W(W)) i_iq_serial_streamer (
      .clk(clk), .rst(rst), .cfg_q_first(cfg_q_first), .cfg_lsb_first(cfg_lsb_first),
      .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_i(smp_i), .smp_q(smp_q),
      .ser_clk(ser_clk), .ser_strobe(ser_strobe), .ser_data(ser_data));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("[TB] FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_bit(input logic [W-1:0] wi, input logic [W-1:0] wq,
                                  input bit qf, input bit lsb, input int b);
      logic [W-1:0] w;
      int pos, idx;
      w   = ((b < W) != qf) ? wi : wq;
      pos = b % W;
      idx = lsb ? pos : W - 1 - pos;
      return w[idx];
   endfunction

   // Inputs for the frame are already presented at the current negedge.
   task automatic send_frame(input logic [W-1:0] fi, input logic [W-1:0] fq,
                             input bit qf, input bit lsb);
      for (int b = 0; b < F; b++) begin
         @(negedge clk);
         chk(ser_strobe == (b == 0), "R5 strobe", ser_strobe, (b == 0));
         chk(ser_data == exp_bit(fi, fq, qf, lsb, b), "R2/R3/R4 data bit",
             ser_data, exp_bit(fi, fq, qf, lsb, b));
         if (b == 0) begin
            smp_i = ~fi; smp_q = ~fq; smp_valid = 1'b1;  // R10 offer during frame
         end
         if (b == 1) chk(smp_ready == 1'b0, "R10 busy ready", smp_ready, 0);
         if (b == 3) begin
            cfg_q_first = ~qf; cfg_lsb_first = ~lsb;     // R8 mid-frame change
         end
         if (b == F - 2) smp_valid = 1'b0;
         if (b == F - 1) chk(smp_ready == 1'b1, "R6 ready on last bit", smp_ready, 1);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [W-1:0] vi, vq;
      repeat (3) @(negedge clk);
      chk(ser_strobe == 0, "R9 reset strobe", ser_strobe, 0);
      chk(ser_data == 0, "R9 reset data", ser_data, 0);
      chk(smp_ready == 1, "R9 reset ready", smp_ready, 1);
      rst = 1'b0;
      @(negedge clk);
      chk(ser_clk == 1'b0, "R1 ser_clk low", ser_clk, 0);
      #6;
      chk(ser_clk == 1'b1, "R1 ser_clk high", ser_clk, 1);
      @(negedge clk);
      chk(!ser_data && !ser_strobe && smp_ready, "R7 idle", ser_data, 0);

      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k < 6; k++) begin
            if (k == 0) begin
               vi = '1; vq = '0;
            end else begin
               vi = W'(16'h8001 + k * 16'h1357 + c);
               vq = W'(16'h7FFE ^ (k * 16'h2468));
            end
            cfg_q_first = c[0]; cfg_lsb_first = c[1];
            smp_i = vi; smp_q = vq; smp_valid = 1'b1;
            send_frame(vi, vq, c[0], c[1]);
            if (k % 2 == 0) begin
               // gap: next negedge must be idle (R7)
               smp_valid = 1'b0;
               @(negedge clk);
               chk(!ser_data && !ser_strobe, "R7 idle after frame", ser_data, 0);
               chk(smp_ready == 1'b1, "R7 ready when idle", smp_ready, 1);
            end
            // odd k: next pair is offered at the last-bit negedge (R6 back to back)
         end
      end
      smp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!ser_data && !ser_strobe, "R7 final idle", ser_data, 0);

      // R9: reset in the middle of a frame
      smp_i = 16'hFFFF; smp_q = 16'hFFFF; cfg_q_first = 0; cfg_lsb_first = 0;
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      chk(ser_strobe == 1'b1, "R5 strobe before reset", ser_strobe, 1);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(ser_data == 0, "R9 mid-frame reset data", ser_data, 0);
      chk(ser_strobe == 0, "R9 mid-frame reset strobe", ser_strobe, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(ser_data == 0, "R9 stays idle", ser_data, 0);
      chk(smp_ready == 1, "R9 ready after reset", smp_ready, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule